// File: doc/BRIEF.md
# SCSI Bus Controller Interrupt and Status Unit

This unit produces the single interrupt request of a SCSI bus controller and assembles its two readable status bytes. It watches the sampled SCSI control lines, the data bus and its parity bit, and a few inputs from the neighbouring logic: mode bits, the local bit that drives the bus reset line, the DMA-finished indication, the phase-match, busy-error and DMA-request flags. Three kinds of event are handled here. The first is a bus reset, which is always reported. The second is a parity error on a received byte. The third is the end of a DMA transfer, which is reported as a status bit.

A bus reset comes either from the RST line or from the local assert bit. It raises the interrupt and asks the bus-driver logic to release every signal it drives. Parity is odd over the eight data bits plus the parity bit. It is checked only when the CPU reads the live data register or when a byte arrives during a DMA receive. A detected error is latched as a flag. It raises the interrupt only when two separate mode bits are both set. Software clears the interrupt and the parity flag with a dedicated clear read.

Top module: `scsi_irq_status`

## Requirements
- R1: A rising edge of (bus_rst OR icr_assert_rst) sets irq_out at the next clock edge, whatever the mode bits are. A level held high does not raise it again after a clear.
- R2: release_all goes high at the same edge as the R1 interrupt. If the reset source is high for L cycles, release_all stays high for max(L, HOLD_CYC) cycles.
- R3: bus_line_stat bits 7..0 read as {0, BSY, REQ, MSG, C/D, I/O, SEL, DBP}. Each bit shows its input one cycle later. Bit 7 reads 0 even while RST is asserted.
- R4: bus_and_stat bits 7..0 read as {end-of-DMA, DMA request, parity-error flag, interrupt active, phase match, busy error, ATN, ACK`}`. The four line fields and the two DMA fields show their inputs one cycle later.
- R5: A parity error is a 9-bit value {dbp, data} with an even count of ones. The check is made only in a cycle where cpu_data_rd or dma_rx_byte is high and mode_par_chk is 1. A detected error sets bus_and_stat bit 5 at the next edge.
- R6: A parity error sets irq_out only when mode_par_chk and mode_par_irq are both 1. Otherwise only the flag is set.
- R7: A cycle with irq_clr_rd high clears irq_out, bus_and_stat bit 4 and bus_and_stat bit 5 at the next edge. An interrupt or parity event in the same cycle wins over the clear.
- R8: End-of-DMA (bus_and_stat bit 7) follows dma_done one cycle later, whatever the state of REQ and ACK.
- R9: After a synchronous reset, with all inputs low, irq_out, release_all and both status bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | Sampled SCSI RST line |
| bus_bsy | input | 1 | Sampled BSY |
| bus_req | input | 1 | Sampled REQ |
| bus_ack | input | 1 | Sampled ACK |
| bus_atn | input | 1 | Sampled ATN |
| bus_sel | input | 1 | Sampled SEL |
| bus_msg | input | 1 | Sampled MSG |
| bus_cd | input | 1 | Sampled C/D |
| bus_io | input | 1 | Sampled I/O |
| bus_dbp | input | 1 | Sampled data-bus parity bit |
| bus_data | input | DATA_W | Sampled data bus |
| cpu_data_rd | input | 1 | Strobe for a CPU read of the live data register |
| dma_rx_byte | input | 1 | Strobe for a byte received during a DMA receive |
| mode_par_chk | input | 1 | Mode bit that enables the parity check |
| mode_par_irq | input | 1 | Mode bit that enables the parity interrupt |
| icr_assert_rst | input | 1 | Local command bit that asserts RST |
| dma_done | input | 1 | DMA side has finished its transfers |
| phase_match | input | 1 | Phase-match flag from the phase logic |
| busy_err | input | 1 | Busy-loss flag from the bus monitor |
| dma_req | input | 1 | DMA request from the DMA engine |
| irq_clr_rd | input | 1 | Clear read for the interrupt and the parity flag |
| irq_out | output | 1 | Interrupt request |
| release_all | output | 1 | Request to release all driven bus signals |
| bus_and_stat | output | 8 | Bus-and-status byte |
| bus_line_stat | output | 8 | Current bus-line status byte |

## Verification
The bench builds the unit with DATA_W = 8 and HOLD_CYC = 4. The short hold lets the release window be measured for reset pulses both shorter and longer than the hold. The 8-bit data width lets the bench sweep every value of data and parity bit under all four mode-bit combinations, with no strobe, with the CPU strobe and with the DMA strobe. It also sweeps all 8192 combinations of the thirteen status-line inputs.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;

    localparam int BYTE_W = 8;

    // Live bus lines shown in the line-status byte, MSB first (bit 7 is RST, never shown)
    typedef struct packed {
        logic bsy;
        logic req;
        logic msg;
        logic cd;
        logic io;
        logic sel;
        logic dbp;
    } line_snap_t;

    // Inputs mirrored into the bus-and-status byte
    typedef struct packed {
        logic eod;
        logic dreq;
        logic phase;
        logic busy;
        logic atn;
        logic ack;
    } aux_snap_t;

    // Odd parity over data plus parity bit: an even count of ones is an error
    function automatic logic parity_bad(input logic [BYTE_W-1:0] d, input logic p);
        return ~(^{p, d});
    endfunction

    function automatic logic [BYTE_W-1:0] pack_line(input line_snap_t s);
        return {1'b0, s.bsy, s.req, s.msg, s.cd, s.io, s.sel, s.dbp};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_bsr(input aux_snap_t a,
                                                   input logic par_flag,
                                                   input logic irq_flag);
        return {a.eod, a.dreq, par_flag, irq_flag, a.phase, a.busy, a.atn, a.ack};
    endfunction

endpackage

// File: rtl/scsi_par_chk.sv
module scsi_par_chk #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              dbp,
    input  logic              strobe_cpu,
    input  logic              strobe_dma,
    input  logic              chk_en,
    output logic              par_evt
);
    logic ones_odd;

    always_comb begin
        ones_odd = dbp;
        for (int i = 0; i < DATA_W; i++) begin
            ones_odd = ones_odd ^ data[i];
        end
        par_evt = chk_en && (strobe_cpu || strobe_dma) && !ones_odd;
    end

endmodule

// File: rtl/scsi_rst_detect.sv
module scsi_rst_detect #(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic line_rst,
    input  logic local_rst,
    output logic rise,
    output logic release_all
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    logic             src;
    logic             src_q;
    logic [CNT_W-1:0] hold_cnt;

    assign src  = line_rst || local_rst;
    assign rise = src && !src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q    <= 1'b0;
            hold_cnt <= '0;
        end else begin
            src_q <= src;
            if (rise) begin
                hold_cnt <= CNT_W'(HOLD_CYC);
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end

    assign release_all = src_q || (hold_cnt != '0);

    // R2: release requested at the edge following a reset rise
    a_r2_release_on_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> release_all);

    // R2: release held while the source stays high
    a_r2_release_held: assert property (@(posedge clk) disable iff (rst)
        src |=> release_all);

endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
    import scsi_irq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HOLD_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              bus_bsy,
    input  logic              bus_req,
    input  logic              bus_ack,
    input  logic              bus_atn,
    input  logic              bus_sel,
    input  logic              bus_msg,
    input  logic              bus_cd,
    input  logic              bus_io,
    input  logic              bus_dbp,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              cpu_data_rd,
    input  logic              dma_rx_byte,
    input  logic              mode_par_chk,
    input  logic              mode_par_irq,
    input  logic              icr_assert_rst,
    input  logic              dma_done,
    input  logic              phase_match,
    input  logic              busy_err,
    input  logic              dma_req,
    input  logic              irq_clr_rd,
    output logic              irq_out,
    output logic              release_all,
    output logic [7:0]        bus_and_stat,
    output logic [7:0]        bus_line_stat
);
    logic       rst_rise;
    logic       par_evt;
    logic       irq_q;
    logic       par_flag_q;
    line_snap_t line_q;
    aux_snap_t  aux_q;

    scsi_rst_detect #(.HOLD_CYC(HOLD_CYC)) u_rst_det (
        .clk        (clk),
        .rst        (rst),
        .line_rst   (bus_rst),
        .local_rst  (icr_assert_rst),
        .rise       (rst_rise),
        .release_all(release_all)
    );

    scsi_par_chk #(.DATA_W(DATA_W)) u_par_chk (
        .data      (bus_data),
        .dbp       (bus_dbp),
        .strobe_cpu(cpu_data_rd),
        .strobe_dma(dma_rx_byte),
        .chk_en    (mode_par_chk),
        .par_evt   (par_evt)
    );

    logic irq_set;
    assign irq_set = rst_rise || (par_evt && mode_par_irq);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q      <= 1'b0;
            par_flag_q <= 1'b0;
            line_q     <= '0;
            aux_q      <= '0;
        end else begin
            if (irq_set)         irq_q <= 1'b1;
            else if (irq_clr_rd) irq_q <= 1'b0;

            if (par_evt)         par_flag_q <= 1'b1;
            else if (irq_clr_rd) par_flag_q <= 1'b0;

            line_q <= '{bsy: bus_bsy, req: bus_req, msg: bus_msg, cd: bus_cd,
                        io: bus_io, sel: bus_sel, dbp: bus_dbp};
            aux_q  <= '{eod: dma_done, dreq: dma_req, phase: phase_match,
                        busy: busy_err, atn: bus_atn, ack: bus_ack};
        end
    end

    assign irq_out       = irq_q;
    assign bus_line_stat = pack_line(line_q);
    assign bus_and_stat  = pack_bsr(aux_q, par_flag_q, irq_q);

    // R1: a reset rise always raises the interrupt
    a_r1_rst_irq: assert property (@(posedge clk) disable iff (rst)
        rst_rise |=> irq_out);

    // R6: the interrupt only rises after a reset rise or an enabled parity error
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> ($past(rst_rise) || ($past(par_evt) && $past(mode_par_irq))));

    // R5: the parity flag only rises while checking is enabled
    a_r5_flag_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_and_stat[5]) |-> $past(mode_par_chk));

    // R7: the clear read with no competing event empties both flags
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (irq_clr_rd && !rst_rise && !par_evt) |=> (!irq_out && !bus_and_stat[5]));

    // R4: the interrupt-active bit mirrors the request line
    a_r4_irq_bit: assert property (@(posedge clk) disable iff (rst)
        bus_and_stat[4] == irq_out);

endmodule

// File: tb/scsi_irq_status_tb.sv
module scsi_irq_status_tb;
    localparam int DATA_W = 8;
    localparam int HOLD   = 4;

    logic clk = 1'b0;
    logic rst;
    logic bus_rst, bus_bsy, bus_req, bus_ack, bus_atn, bus_sel, bus_msg;
    logic bus_cd, bus_io, bus_dbp;
    logic [DATA_W-1:0] bus_data;
    logic cpu_data_rd, dma_rx_byte, mode_par_chk, mode_par_irq, icr_assert_rst;
    logic dma_done, phase_match, busy_err, dma_req, irq_clr_rd;
    logic irq_out, release_all;
    logic [7:0] bus_and_stat, bus_line_stat;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    scsi_irq_status #(.DATA_W(DATA_W), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .bus_bsy(bus_bsy),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_atn(bus_atn),
        .bus_sel(bus_sel), .bus_msg(bus_msg), .bus_cd(bus_cd), .bus_io(bus_io),
        .bus_dbp(bus_dbp), .bus_data(bus_data), .cpu_data_rd(cpu_data_rd),
        .dma_rx_byte(dma_rx_byte), .mode_par_chk(mode_par_chk),
        .mode_par_irq(mode_par_irq), .icr_assert_rst(icr_assert_rst),
        .dma_done(dma_done), .phase_match(phase_match), .busy_err(busy_err),
        .dma_req(dma_req), .irq_clr_rd(irq_clr_rd), .irq_out(irq_out),
        .release_all(release_all), .bus_and_stat(bus_and_stat),
        .bus_line_stat(bus_line_stat)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        {bus_rst, bus_bsy, bus_req, bus_ack, bus_atn, bus_sel, bus_msg} = '0;
        {bus_cd, bus_io, bus_dbp, cpu_data_rd, dma_rx_byte} = '0;
        {mode_par_chk, mode_par_irq, icr_assert_rst, dma_done} = '0;
        {phase_match, busy_err, dma_req, irq_clr_rd} = '0;
        bus_data = '0;
    endtask

    task automatic clear_read();
        irq_clr_rd = 1'b1;
        tick();
        irq_clr_rd = 1'b0;
    endtask

    // Pulse the reset source for len cycles and count release cycles
    task automatic rst_pulse(input int len, input bit local_src, input string tag);
        int high_cnt = 0;
        if (local_src) icr_assert_rst = 1'b1; else bus_rst = 1'b1;
        for (int i = 1; i <= len + HOLD + 6; i++) begin
            tick();
            if (i == 1) begin
                chk({tag, " irq after reset rise"}, {7'd0, irq_out}, 8'd1);
                chk({tag, " irq bit in status"}, {7'd0, bus_and_stat[4]}, 8'd1);
            end
            if (release_all) high_cnt++;
            if (i == len) begin
                bus_rst = 1'b0;
                icr_assert_rst = 1'b0;
            end
        end
        chk({tag, " release length"}, 8'(high_cnt), 8'((len > HOLD) ? len : HOLD));
        clear_read();
        chk({tag, " irq cleared"}, {7'd0, irq_out}, 8'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R9: reset state
        chk("R9 irq", {7'd0, irq_out}, 8'd0);
        chk("R9 release", {7'd0, release_all}, 8'd0);
        chk("R9 bus_and_stat", bus_and_stat, 8'd0);
        chk("R9 line stat", bus_line_stat, 8'd0);

        // R3 R4 R8: sweep all status-line inputs
        for (int p = 0; p < 8192; p++) begin
            logic [12:0] v;
            v = 13'(p);
            bus_ack = v[0]; bus_atn = v[1]; busy_err = v[2]; phase_match = v[3];
            dma_req = v[4]; dma_done = v[5]; bus_dbp = v[6]; bus_sel = v[7];
            bus_io = v[8]; bus_cd = v[9]; bus_msg = v[10]; bus_req = v[11];
            bus_bsy = v[12];
            tick();
            chk("R3 line status", bus_line_stat,
                {1'b0, v[12], v[11], v[10], v[9], v[8], v[7], v[6]});
            chk("R4 R8 bus and status", bus_and_stat,
                {v[5], v[4], 2'b00, v[3], v[2], v[1], v[0]});
        end
        idle();
        tick();

        // R5 R6 R7: parity under every mode, strobe and data value
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 3; s++) begin
                for (int v = 0; v < 512; v++) begin
                    logic [8:0] w;
                    logic bad;
                    logic flag_exp;
                    logic irq_exp;
                    w = 9'(v);
                    bad = ~(^w);
                    flag_exp = (s != 0) && m[0] && bad;
                    irq_exp = flag_exp && m[1];
                    mode_par_chk = m[0];
                    mode_par_irq = m[1];
                    bus_data = w[7:0];
                    bus_dbp = w[8];
                    clear_read();
                    cpu_data_rd = (s == 1);
                    dma_rx_byte = (s == 2);
                    tick();
                    cpu_data_rd = 1'b0;
                    dma_rx_byte = 1'b0;
                    chk("R5 parity flag", {7'd0, bus_and_stat[5]}, {7'd0, flag_exp});
                    chk("R6 parity irq", {7'd0, irq_out}, {7'd0, irq_exp});
                end
            end
        end
        clear_read();
        chk("R7 flags cleared", bus_and_stat, {3'b000, 1'b0, 4'h0});

        // R7: event beats clear in the same cycle
        mode_par_chk = 1'b1;
        mode_par_irq = 1'b1;
        bus_data = 8'h00;
        bus_dbp = 1'b0;
        cpu_data_rd = 1'b1;
        irq_clr_rd = 1'b1;
        tick();
        cpu_data_rd = 1'b0;
        irq_clr_rd = 1'b0;
        chk("R7 set wins flag", {7'd0, bus_and_stat[5]}, 8'd1);
        chk("R7 set wins irq", {7'd0, irq_out}, 8'd1);
        clear_read();
        chk("R7 clear irq", {7'd0, irq_out}, 8'd0);
        chk("R7 clear flag", {7'd0, bus_and_stat[5]}, 8'd0);
        idle();

        // R1 R2: bus reset from the line and from the local bit, masks off
        rst_pulse(1, 1'b0, "R1 R2 line short");
        rst_pulse(7, 1'b0, "R1 R2 line long");
        rst_pulse(1, 1'b1, "R1 R2 local short");
        rst_pulse(HOLD, 1'b1, "R1 R2 local equal");

        // R1: a held reset line does not re-raise after a clear; R3 hides RST
        bus_rst = 1'b1;
        tick();
        chk("R1 held irq", {7'd0, irq_out}, 8'd1);
        chk("R3 RST hidden", {7'd0, bus_line_stat[7]}, 8'd0);
        clear_read();
        tick();
        chk("R1 level no re-raise", {7'd0, irq_out}, 8'd0);
        chk("R2 release while held", {7'd0, release_all}, 8'd1);
        bus_rst = 1'b0;
        repeat (HOLD + 2) tick();
        chk("R2 release dropped", {7'd0, release_all}, 8'd0);

        // R8: end of DMA with the handshake still active
        bus_req = 1'b1;
        bus_ack = 1'b1;
        dma_done = 1'b1;
        tick();
        chk("R8 eod during handshake", {7'd0, bus_and_stat[7]}, 8'd1);
        dma_done = 1'b0;
        tick();
        chk("R8 eod follows input", {7'd0, bus_and_stat[7]}, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule